// File: doc/BRIEF.md
# Hash Bin Prefix Lookup with Overflow Chain

This block searches one table of prefixes that were all expanded to a single fixed length. A caller supplies the key, already cut to that length, together with the bin index its hash produced. The block reads that bin and compares the key against every valid slot at the same time. A bin that received more keys than it has slots gives up its last slot. That slot then holds a pointer into a separate overflow RAM. The RAM is plain addressed storage, not a content-addressable memory, and the block walks it one word per clock after checking the remaining in-bin slots.

One lookup is in flight at a time. A request is taken through a valid/ready handshake. The answer comes back as a one-cycle pulse carrying hit and the next-hop index. Both tables are synchronous RAMs filled through two simple write ports by whatever builds the table. Defaults fit the 24-bit table: three slots per bin and up to eight overflow words per spilled bin. Parameters set slot count, key width, next-hop width and both depths.

Top module: `hbl_lookup`

## Requirements
- R1: After reset, reqReady is 1 and respValid is 0.
- R2: A request is taken only on a clock edge where reqValid and reqReady are both 1. reqReady stays 0 from that edge until the response has been given. Requests offered while reqReady is 0 are ignored and produce no response.
- R3: A bin word places slot i at bits [i*SLOT_W +: SLOT_W]. Each slot is {tag[1:0], key, nextHop}, with the tag in the most significant bits. A slot tagged 01 (entry) whose key equals the request key gives respHit=1 with that slot's next hop. This holds for the last slot too, and respValid rises one clock after the accepting edge.
- R4: Slots tagged 00 (empty) or 11 (reserved) never match, whatever their key field holds. Tag 10 (pointer) counts only in the last slot; in any other slot it is treated as empty. A pointer slot is never matched as a key.
- R5: If no slot matches and the last slot is not tagged 10, the result is a miss one clock after the accepting edge.
- R6: If the last slot is tagged 10, its key field's low OVF_AW bits give an overflow address. The in-bin slots are checked first. On no match, overflow words are read from that address upward, one per clock. A match (tag 01, equal key) at word k gives a hit with that word's next hop, and respValid rises 2+k clocks after the accepting edge.
- R7: The overflow scan stops at the first word whose tag is not 01 and reports a miss. Words after it are never examined.
- R8: The overflow scan examines at most OVF_EXTRA+1 words. A key stored only past that limit is a miss, reported OVF_EXTRA+2 clocks after the accepting edge.
- R9: When several locations match, the lowest in-bin slot wins over higher slots. Any in-bin match wins over the overflow memory, and within the overflow region the first matching word wins.
- R10: respValid is high for exactly one cycle per accepted request. On a miss, respNh is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqKey | input | KEY_W | Expanded lookup key |
| reqHash | input | BIN_AW | Bin index from the hash |
| respValid | output | 1 | One-cycle result strobe |
| respHit | output | 1 | Key found |
| respNh | output | NH_W | Next-hop index, 0 on miss |
| binWrEn | input | 1 | Bin table write enable |
| binWrAddr | input | BIN_AW | Bin table write address |
| binWrData | input | BIN_SLOTS*SLOT_W | Whole bin word |
| ovfWrEn | input | 1 | Overflow memory write enable |
| ovfWrAddr | input | OVF_AW | Overflow memory write address |
| ovfWrData | input | SLOT_W | Overflow word {tag, key, nextHop} |

## Verification
The bench targets the slot tags. It stores keys behind empty, reserved and misplaced pointer tags, and looks up a pointer's own key field. A design that decoded tags loosely would report false hits there. Overflow scans are run to their first word, a middle word, the last permitted word and one word beyond it. Further scans stop at an empty word placed ahead of a real entry. An off-by-one scan limit or a missing early stop shows up as a wrong hit or a wrong latency. Duplicate keys in a bin and in its overflow region expose a wrong priority. A long lookup is bombarded with further requests to show that a busy block neither takes them nor answers twice.

// File: rtl/hbl_pkg.sv
package hbl_pkg;

  typedef enum logic [1:0] {
    TAG_EMPTY = 2'b00,
    TAG_ENTRY = 2'b01,
    TAG_PTR   = 2'b10,
    TAG_RSVD  = 2'b11
  } slotTag_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic latchReq;   // capture key and read the bin
    logic startOvf;   // first overflow read at the bin pointer
    logic stepOvf;    // next sequential overflow read
    logic loadBin;    // result := in-bin hit
    logic loadOvf;    // result := overflow hit
    logic loadMiss;   // result := miss
  } ctlStrobe_t;

  // compare results from the datapath to the controller
  typedef struct packed {
    logic binHit;
    logic binHasPtr;
    logic ovfHit;
    logic ovfEnd;     // empty word or scan limit reached
  } dpStatus_t;

endpackage

// File: rtl/hbl_ctrl.sv
module hbl_ctrl
  import hbl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  dpStatus_t  st,
  output logic       reqReady,
  output logic       respValid,
  output ctlStrobe_t ctl
);

  typedef enum logic [1:0] {S_IDLE, S_BIN, S_OVF, S_RESP} state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateD       = S_BIN;
        end
      end
      S_BIN: begin
        if (st.binHit) begin
          ctl.loadBin = 1'b1;
          stateD      = S_RESP;
        end else if (st.binHasPtr) begin
          ctl.startOvf = 1'b1;
          stateD       = S_OVF;
        end else begin
          ctl.loadMiss = 1'b1;
          stateD       = S_RESP;
        end
      end
      S_OVF: begin
        if (st.ovfHit) begin
          ctl.loadOvf = 1'b1;
          stateD      = S_RESP;
        end else if (st.ovfEnd) begin
          ctl.loadMiss = 1'b1;
          stateD       = S_RESP;
        end else begin
          ctl.stepOvf = 1'b1;
        end
      end
      S_RESP: stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  assign reqReady  = (stateQ == S_IDLE);
  assign respValid = (stateQ == S_RESP);

endmodule

// File: rtl/hbl_dpath.sv
module hbl_dpath
  import hbl_pkg::*;
#(
  parameter int KEY_W     = 24,
  parameter int NH_W      = 8,
  parameter int BIN_SLOTS = 3,
  parameter int OVF_EXTRA = 7,
  parameter int BIN_AW    = 4,
  parameter int OVF_AW    = 6,
  localparam int SLOT_W   = 2 + KEY_W + NH_W,
  localparam int BIN_W    = BIN_SLOTS * SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [KEY_W-1:0]  reqKey,
  input  logic [BIN_AW-1:0] reqHash,
  input  logic              binWrEn,
  input  logic [BIN_AW-1:0] binWrAddr,
  input  logic [BIN_W-1:0]  binWrData,
  input  logic              ovfWrEn,
  input  logic [OVF_AW-1:0] ovfWrAddr,
  input  logic [SLOT_W-1:0] ovfWrData,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         st,
  output logic              respHit,
  output logic [NH_W-1:0]   respNh
);

  localparam int BIN_DEPTH = 1 << BIN_AW;
  localparam int OVF_DEPTH = 1 << OVF_AW;
  localparam int CNT_W     = $clog2(OVF_EXTRA + 2);
  localparam int LAST      = BIN_SLOTS - 1;

  // ---------------- storage ----------------
  logic [BIN_W-1:0]  binMem [BIN_DEPTH];
  logic [SLOT_W-1:0] ovfMem [OVF_DEPTH];

  logic [KEY_W-1:0]  keyQ;
  logic [BIN_W-1:0]  binQ;
  logic [SLOT_W-1:0] ovfQ;
  logic [OVF_AW-1:0] ovfAddrQ;
  logic [CNT_W-1:0]  ovfCntQ;
  logic [OVF_AW-1:0] ovfRdAddr;
  logic [OVF_AW-1:0] binPtr;

  always_ff @(posedge clk) begin
    if (binWrEn) binMem[binWrAddr] <= binWrData;
    if (ctl.latchReq) binQ <= binMem[reqHash];
  end

  always_ff @(posedge clk) begin
    if (ovfWrEn) ovfMem[ovfWrAddr] <= ovfWrData;
    if (ctl.startOvf || ctl.stepOvf) ovfQ <= ovfMem[ovfRdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ     <= '0;
      ovfAddrQ <= '0;
      ovfCntQ  <= '0;
    end else begin
      if (ctl.latchReq) keyQ <= reqKey;
      if (ctl.startOvf) begin
        ovfAddrQ <= ovfRdAddr;
        ovfCntQ  <= '0;
      end else if (ctl.stepOvf) begin
        ovfAddrQ <= ovfRdAddr;
        ovfCntQ  <= ovfCntQ + 1'b1;
      end
    end
  end

  assign ovfRdAddr = ctl.startOvf ? binPtr : ovfAddrQ + 1'b1;

  // ---------------- in-bin compare ----------------
  logic [1:0]       slotTag [BIN_SLOTS];
  logic [KEY_W-1:0] slotKey [BIN_SLOTS];
  logic [NH_W-1:0]  slotNh  [BIN_SLOTS];
  logic [BIN_SLOTS-1:0] slotHit;

  for (genvar i = 0; i < BIN_SLOTS; i++) begin : g_slot
    assign slotTag[i] = binQ[i*SLOT_W + NH_W + KEY_W +: 2];
    assign slotKey[i] = binQ[i*SLOT_W + NH_W +: KEY_W];
    assign slotNh[i]  = binQ[i*SLOT_W +: NH_W];
    assign slotHit[i] = (slotTag[i] == TAG_ENTRY) && (slotKey[i] == keyQ);
  end

  assign binPtr = slotKey[LAST][OVF_AW-1:0];

  logic [NH_W-1:0] binNhSel;
  always_comb begin
    binNhSel = '0;
    for (int i = LAST; i >= 0; i--) begin
      if (slotHit[i]) binNhSel = slotNh[i];
    end
  end

  // ---------------- overflow compare ----------------
  logic [1:0]       ovfTag;
  logic [KEY_W-1:0] ovfKey;
  logic [NH_W-1:0]  ovfNh;

  assign ovfTag = ovfQ[NH_W + KEY_W +: 2];
  assign ovfKey = ovfQ[NH_W +: KEY_W];
  assign ovfNh  = ovfQ[0 +: NH_W];

  assign st.binHit    = |slotHit;
  assign st.binHasPtr = (slotTag[LAST] == TAG_PTR);
  assign st.ovfHit    = (ovfTag == TAG_ENTRY) && (ovfKey == keyQ);
  assign st.ovfEnd    = (ovfTag != TAG_ENTRY) || (ovfCntQ == CNT_W'(OVF_EXTRA));

  // ---------------- result ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respHit <= 1'b0;
      respNh  <= '0;
    end else if (ctl.loadBin) begin
      respHit <= 1'b1;
      respNh  <= binNhSel;
    end else if (ctl.loadOvf) begin
      respHit <= 1'b1;
      respNh  <= ovfNh;
    end else if (ctl.loadMiss) begin
      respHit <= 1'b0;
      respNh  <= '0;
    end
  end

endmodule

// File: rtl/hbl_lookup.sv
module hbl_lookup
  import hbl_pkg::*;
#(
  parameter int KEY_W     = 24,
  parameter int NH_W      = 8,
  parameter int BIN_SLOTS = 3,
  parameter int OVF_EXTRA = 7,
  parameter int BIN_AW    = 4,
  parameter int OVF_AW    = 6,
  localparam int SLOT_W   = 2 + KEY_W + NH_W,
  localparam int BIN_W    = BIN_SLOTS * SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [KEY_W-1:0]  reqKey,
  input  logic [BIN_AW-1:0] reqHash,
  output logic              respValid,
  output logic              respHit,
  output logic [NH_W-1:0]   respNh,
  input  logic              binWrEn,
  input  logic [BIN_AW-1:0] binWrAddr,
  input  logic [BIN_W-1:0]  binWrData,
  input  logic              ovfWrEn,
  input  logic [OVF_AW-1:0] ovfWrAddr,
  input  logic [SLOT_W-1:0] ovfWrData
);

  ctlStrobe_t ctl;
  dpStatus_t  st;

  hbl_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .st        (st),
    .reqReady  (reqReady),
    .respValid (respValid),
    .ctl       (ctl)
  );

  hbl_dpath #(
    .KEY_W     (KEY_W),
    .NH_W      (NH_W),
    .BIN_SLOTS (BIN_SLOTS),
    .OVF_EXTRA (OVF_EXTRA),
    .BIN_AW    (BIN_AW),
    .OVF_AW    (OVF_AW)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqKey    (reqKey),
    .reqHash   (reqHash),
    .binWrEn   (binWrEn),
    .binWrAddr (binWrAddr),
    .binWrData (binWrData),
    .ovfWrEn   (ovfWrEn),
    .ovfWrAddr (ovfWrAddr),
    .ovfWrData (ovfWrData),
    .ctl       (ctl),
    .st        (st),
    .respHit   (respHit),
    .respNh    (respNh)
  );

endmodule

// File: rtl/hbl_checker.sv
module hbl_checker #(
  parameter int NH_W      = 8,
  parameter int OVF_EXTRA = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            respValid,
  input logic            respHit,
  input logic [NH_W-1:0] respNh
);

  localparam int LAT_W = $clog2(OVF_EXTRA + 4) + 1;

  logic             inFlight;
  logic [LAT_W-1:0] latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      latCnt   <= '0;
    end else if (reqValid && reqReady) begin
      inFlight <= 1'b1;
      latCnt   <= '0;
    end else if (respValid) begin
      inFlight <= 1'b0;
    end else if (inFlight && latCnt != '1) begin
      latCnt <= latCnt + 1'b1;
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2

  AST_RESP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (!reqReady && inFlight)); // R2

  AST_RESP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid); // R10

  AST_MISS_NH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respNh == '0)); // R10

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (latCnt >= LAT_W'(1) && latCnt <= LAT_W'(OVF_EXTRA + 2))); // R8

endmodule

bind hbl_lookup hbl_checker #(
  .NH_W      (NH_W),
  .OVF_EXTRA (OVF_EXTRA)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .respValid (respValid),
  .respHit   (respHit),
  .respNh    (respNh)
);

// File: tb/hbl_lookup_tb_top.sv
`timescale 1ns/1ps
module hbl_lookup_tb_top;

  localparam int KEY_W  = 24;
  localparam int NH_W   = 8;
  localparam int SLOTS  = 3;
  localparam int EXTRA  = 7;
  localparam int BIN_AW = 4;
  localparam int OVF_AW = 6;
  localparam int SLOT_W = 2 + KEY_W + NH_W;
  localparam int BIN_W  = SLOTS * SLOT_W;

  localparam logic [1:0] T_EMP = 2'b00;
  localparam logic [1:0] T_ENT = 2'b01;
  localparam logic [1:0] T_PTR = 2'b10;
  localparam logic [1:0] T_RSV = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [KEY_W-1:0] reqKey = '0;
  logic [BIN_AW-1:0] reqHash = '0;
  logic respValid, respHit;
  logic [NH_W-1:0] respNh;
  logic binWrEn = 1'b0;
  logic [BIN_AW-1:0] binWrAddr = '0;
  logic [BIN_W-1:0] binWrData = '0;
  logic ovfWrEn = 1'b0;
  logic [OVF_AW-1:0] ovfWrAddr = '0;
  logic [SLOT_W-1:0] ovfWrData = '0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hbl_lookup dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKey(reqKey), .reqHash(reqHash), .respValid(respValid),
    .respHit(respHit), .respNh(respNh), .binWrEn(binWrEn),
    .binWrAddr(binWrAddr), .binWrData(binWrData), .ovfWrEn(ovfWrEn),
    .ovfWrAddr(ovfWrAddr), .ovfWrData(ovfWrData)
  );

  function automatic logic [SLOT_W-1:0] mkSlot(logic [1:0] t, logic [KEY_W-1:0] k, logic [NH_W-1:0] n);
    return {t, k, n};
  endfunction

  task automatic writeBin(input logic [BIN_AW-1:0] a, input logic [SLOT_W-1:0] s0,
                          input logic [SLOT_W-1:0] s1, input logic [SLOT_W-1:0] s2);
    @(negedge clk);
    binWrEn = 1'b1; binWrAddr = a; binWrData = {s2, s1, s0};
    @(negedge clk);
    binWrEn = 1'b0;
  endtask

  task automatic writeOvf(input logic [OVF_AW-1:0] a, input logic [SLOT_W-1:0] w);
    @(negedge clk);
    ovfWrEn = 1'b1; ovfWrAddr = a; ovfWrData = w;
    @(negedge clk);
    ovfWrEn = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // returns hit, nh and edges from accept to the response
  task automatic lookup(input logic [BIN_AW-1:0] h, input logic [KEY_W-1:0] k,
                        output logic hit, output logic [NH_W-1:0] nh, output int lat);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqKey = k; reqHash = h;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid && lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    hit = respHit;
    nh  = respNh;
  endtask

  // {hash[4], key[24], hit[1], nh[8], lat[8], req[4]}
  localparam int NV = 20;
  localparam logic [48:0] VECS [NV] = '{
    {4'd0, 24'h111111, 1'b1, 8'd1,  8'd1, 4'd3},  // R3 slot 0
    {4'd0, 24'h333333, 1'b1, 8'd3,  8'd1, 4'd3},  // R3 last slot as entry
    {4'd1, 24'hAAAAAA, 1'b1, 8'd10, 8'd1, 4'd3},  // R3
    {4'd4, 24'h600000, 1'b1, 8'd50, 8'd1, 4'd3},  // R3 bin with pointer
    {4'd1, 24'hBBBBBB, 1'b0, 8'd0,  8'd1, 4'd4},  // R4 empty tag
    {4'd2, 24'h200000, 1'b0, 8'd0,  8'd1, 4'd4},  // R4 pointer tag mid slot
    {4'd2, 24'h300000, 1'b0, 8'd0,  8'd1, 4'd4},  // R4 reserved tag
    {4'd3, 24'h000008, 1'b0, 8'd0,  8'd9, 4'd4},  // R4 pointer value is no key
    {4'd0, 24'h444444, 1'b0, 8'd0,  8'd1, 4'd5},  // R5
    {4'd1, 24'h111111, 1'b0, 8'd0,  8'd1, 4'd5},  // R5 key of another bin
    {4'd3, 24'h400002, 1'b1, 8'd31, 8'd1, 4'd6},  // R6 in-bin before overflow
    {4'd3, 24'h500000, 1'b1, 8'd40, 8'd2, 4'd6},  // R6 overflow word 0
    {4'd3, 24'h500004, 1'b1, 8'd44, 8'd6, 4'd6},  // R6 overflow word 4
    {4'd4, 24'h610000, 1'b1, 8'd51, 8'd2, 4'd6},  // R6
    {4'd4, 24'h610001, 1'b0, 8'd0,  8'd3, 4'd7},  // R7 key behind empty tag
    {4'd4, 24'h610002, 1'b0, 8'd0,  8'd3, 4'd7},  // R7 entry after empty word
    {4'd3, 24'h500007, 1'b1, 8'd47, 8'd9, 4'd8},  // R8 last permitted word
    {4'd3, 24'h500008, 1'b0, 8'd0,  8'd9, 4'd8},  // R8 one past the limit
    {4'd5, 24'h700000, 1'b1, 8'd60, 8'd1, 4'd9},  // R9 lowest slot wins
    {4'd5, 24'h700001, 1'b1, 8'd62, 8'd2, 4'd9}   // R9 first overflow word wins
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic hit;
    logic [NH_W-1:0] nh;
    int lat;
    int pulses;
    int seenNh;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady in reset", 64'(reqReady), 64'd1);
    check(respValid == 1'b0, "R1", "respValid in reset", 64'(respValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && respValid == 1'b0, "R1", "idle after reset",
          {62'd0, reqReady, respValid}, 64'd2);

    // clear both memories
    for (int a = 0; a < (1 << BIN_AW); a++) writeBin(BIN_AW'(a), '0, '0, '0);
    for (int a = 0; a < (1 << OVF_AW); a++) writeOvf(OVF_AW'(a), '0);

    writeBin(0, mkSlot(T_ENT, 24'h111111, 1), mkSlot(T_ENT, 24'h222222, 2), mkSlot(T_ENT, 24'h333333, 3));
    writeBin(1, mkSlot(T_ENT, 24'hAAAAAA, 10), mkSlot(T_EMP, 24'hBBBBBB, 11), mkSlot(T_EMP, 24'h0, 0));
    writeBin(2, mkSlot(T_ENT, 24'h100000, 20), mkSlot(T_PTR, 24'h200000, 21), mkSlot(T_RSV, 24'h300000, 22));
    writeBin(3, mkSlot(T_ENT, 24'h400001, 30), mkSlot(T_ENT, 24'h400002, 31), mkSlot(T_PTR, 24'h000008, 0));
    for (int k = 0; k <= EXTRA + 1; k++)
      writeOvf(OVF_AW'(8 + k), mkSlot(T_ENT, 24'h500000 + KEY_W'(k), NH_W'(40 + k)));
    writeBin(4, mkSlot(T_ENT, 24'h600000, 50), mkSlot(T_EMP, 24'h0, 0), mkSlot(T_PTR, 24'd20, 0));
    writeOvf(20, mkSlot(T_ENT, 24'h610000, 51));
    writeOvf(21, mkSlot(T_EMP, 24'h610001, 53));
    writeOvf(22, mkSlot(T_ENT, 24'h610002, 52));
    writeBin(5, mkSlot(T_ENT, 24'h700000, 60), mkSlot(T_ENT, 24'h700000, 61), mkSlot(T_PTR, 24'd30, 0));
    writeOvf(30, mkSlot(T_ENT, 24'h700001, 62));
    writeOvf(31, mkSlot(T_ENT, 24'h700001, 63));

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i][48:45], VECS[i][44:21], hit, nh, lat);
      tests++;
      if (hit !== VECS[i][20] || nh !== VECS[i][19:12] || lat != int'(VECS[i][11:4])) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual hit=%0d nh=%0d lat=%0d expected hit=%0d nh=%0d lat=%0d",
                 VECS[i][3:0], i, hit, nh, lat, VECS[i][20], VECS[i][19:12], VECS[i][11:4]);
      end
    end

    // R2 / R10: requests offered while busy are ignored, single pulse
    @(negedge clk);
    reqValid = 1'b1; reqKey = 24'h500007; reqHash = 4'd3;
    @(posedge clk);
    @(negedge clk);
    reqKey = 24'h111111; reqHash = 4'd0;
    pulses = 0;
    seenNh = -1;
    for (int c = 0; c < 20; c++) begin
      if (c < 5) check(reqReady == 1'b0, "R2", "reqReady while busy", 64'(reqReady), 64'd0);
      if (c == 5) reqValid = 1'b0;
      if (respValid) begin
        pulses++;
        seenNh = int'(respNh);
      end
      @(negedge clk);
    end
    check(pulses == 1, "R2", "responses for one accepted request", 64'(pulses), 64'd1);
    check(seenNh == 47, "R2", "response belongs to accepted key", 64'(seenNh), 64'd47);
    check(reqReady == 1'b1, "R2", "ready again after response", 64'(reqReady), 64'd1);

    // R10 pulse width on a plain hit
    lookup(4'd0, 24'h222222, hit, nh, lat);
    check(hit == 1'b1 && nh == 8'd2, "R10", "hit before pulse check", {55'd0, hit, nh}, 64'h102);
    @(negedge clk);
    check(respValid == 1'b0, "R10", "respValid one cycle only", 64'(respValid), 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule